// File: doc/BRIEF.md
# Streaming Raster 2D DCT Engine

This block turns a raster video stream into 8x8 two-dimensional DCT coefficients. Pixels enter one per clock enable and are framed by line and frame sync pulses. The transform runs as two passes that overlap in time.

The row pass gathers each run of eight pixels in a line. It removes the mid-level offset and multiplies the vector by the transposed DCT matrix. It then writes the eight intermediate values into a strip store that holds eight image lines. The write address transposes each block as it is stored. The store has two halves, one for each strip. While the row pass fills one half with the current strip, the column pass reads the previous strip from the other half in plain sequential order. The column pass applies the DCT matrix a second time and streams each block's 64 coefficients with a start flag on the first one.

The engine sits between a pixel capture stage and a quantiser. The image width and the number of strips per frame are parameters. The defaults give a 352 x 288 frame, which is 44 blocks per strip and 36 strips.

Top module: `strip_dct2d`

## Requirements
- R1: Each output coefficient is within plus or minus 1 of the orthonormal double-precision 2D DCT of the block. The block is formed from the pixels minus 128, and pixels are 8-bit unsigned. The DCT is Y[v][u] = a(v) a(u) sum over r,c of x[r][c] cos((2r+1)v pi/16) cos((2c+1)u pi/16), with a(0) = sqrt(1/8) and otherwise a = 1/2.
- R2: Within a block, output number i (0..63) carries Y[v][u] with u = i / 8 (horizontal frequency) and v = i mod 8 (vertical frequency). The column-major order is the transposed form of the result.
- R3: Each block appears as 64 coefficients on 64 consecutive cycles with `coef_valid` high. `blk_start` is high together with the first coefficient only.
- R4: After the 8th line of a strip completes, the strip's blocks are emitted left to right. Block b covers pixel columns 8b..8b+7. All IMG_W/8 blocks of a strip come out before any block of the next strip, and no block is lost or repeated.
- R5: Strip k of a frame is row-transformed into store half k mod 2. The row pass never writes into the half that the column pass is reading.
- R6: An `hsync` pulse returns the pixel column to 0. Pixels accepted before it on a partial line have no effect on any output block.
- R7: A `vsync` pulse returns the line and strip counters and the half select to zero. Lines received before it that did not complete a strip produce no output and do not shift the strip boundaries of the new frame.
- R8: Cycles with `pix_valid` low advance nothing. Output values do not depend on how the valid pixels are spaced in time.
- R9: After reset, `coef_valid` and `blk_start` stay low until a full strip has been received.
- R10: A block of one flat value p gives a DC term of exactly 8*(p-128) and 63 AC terms of exactly zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix | input | 8 | Unsigned pixel sample |
| pix_valid | input | 1 | Pixel sample is valid this cycle |
| hsync | input | 1 | One-cycle pulse before each line's pixels |
| vsync | input | 1 | One-cycle pulse before each frame |
| coef | output | 12 | Signed DCT coefficient |
| coef_valid | output | 1 | Coefficient is valid this cycle |
| blk_start | output | 1 | First coefficient of a block |

## Verification
The checks assume that each strip spends at least 8*IMG_W plus a few clocks on its input. Line blanking must give the column pass time to drain the previous strip before the next strip finishes. They also assume that a frame has an even number of strips, so the first strip of a frame never lands in the half still being read. The stimulus keeps within both limits. Every line carries a dozen blanking cycles on top of randomly spaced valid pixels, and the reduced frame has two strips. Sync pulses are sent only on cycles with `pix_valid` low. A frame is started only after the previous one has drained.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int PIX_W    = 8;
    localparam int MID_W    = 16;
    localparam int COEF_W   = 12;
    localparam int CST_W    = 13;
    localparam int CSCALE   = 11;
    localparam int MID_FRAC = 4;
    localparam int SH_ROW   = CSCALE - MID_FRAC;
    localparam int SH_COL   = CSCALE + MID_FRAC;

    typedef logic signed [PIX_W:0]    pxs_t;
    typedef pxs_t [7:0]               pxvec_t;
    typedef logic signed [MID_W-1:0]  mid_t;
    typedef mid_t [7:0]               midvec_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [CST_W-1:0]  cst_t;

    typedef enum logic {CP_IDLE, CP_RUN} cp_state_t;

    // Scaled cosine basis entry for frequency k at sample n (scale 2^CSCALE).
    function automatic cst_t dct_c(input logic [2:0] k, input logic [2:0] n);
        int t;
        int mag;
        logic neg;
        t   = ((2 * int'(n) + 1) * int'(k)) % 32;
        neg = 1'b0;
        if (t > 16) t = 32 - t;
        if (t > 8) begin
            t   = 16 - t;
            neg = 1'b1;
        end
        case (t)
            0:       mag = (k == 3'd0) ? 724 : 1024;
            1:       mag = 1004;
            2:       mag = 946;
            3:       mag = 851;
            4:       mag = 724;
            5:       mag = 569;
            6:       mag = 392;
            7:       mag = 200;
            default: mag = 0;
        endcase
        return neg ? cst_t'(-mag) : cst_t'(mag);
    endfunction

    // Row pass: one intermediate value, keeping MID_FRAC fraction bits.
    function automatic mid_t row_dot(input pxvec_t x, input logic [2:0] k);
        int acc;
        acc = 0;
        for (int n = 0; n < 8; n++)
            acc += int'(x[n]) * int'(dct_c(k, 3'(n)));
        return mid_t'((acc + (1 <<< (SH_ROW - 1))) >>> SH_ROW);
    endfunction

    // Column pass: one final coefficient from a column of intermediates.
    function automatic coef_t col_dot(input midvec_t h, input logic [2:0] v);
        int acc;
        acc = 0;
        for (int r = 0; r < 8; r++)
            acc += int'(h[r]) * int'(dct_c(v, 3'(r)));
        return coef_t'((acc + (1 <<< (SH_COL - 1))) >>> SH_COL);
    endfunction

endpackage

// File: rtl/dct_row_pass.sv
module dct_row_pass
    import dct_pkg::*;
#(
    parameter int IMG_W  = 352,
    parameter int STRIPS = 36,
    parameter int AW     = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix,
    input  logic             pix_valid,
    input  logic             hsync,
    input  logic             vsync,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output mid_t             wr_data,
    output logic             strip_done,
    output logic             strip_bank
);

    localparam int HALF = 8 * IMG_W;
    localparam int CW   = $clog2(IMG_W);
    localparam int BW   = (CW > 3) ? CW - 3 : 1;
    localparam int SW   = (STRIPS > 1) ? $clog2(STRIPS) : 1;

    typedef struct packed {
        pxvec_t        vec;
        logic [BW-1:0] blk;
        logic [2:0]    line;
        logic          bank;
        logic          last;
    } seg_t;

    logic [CW-1:0] col_q;
    logic [2:0]    line_q;
    logic [SW-1:0] strip_q;
    logic          bank_q;
    pxvec_t        xv_q;
    seg_t          seg_q;
    logic          wact_q;
    logic [2:0]    wk_q;
    logic          done_q;
    logic          dbank_q;

    pxs_t   px_s;
    pxvec_t full_vec;
    logic   seg_end;
    logic   line_end;

    always_comb begin
        px_s        = pxs_t'({1'b0, pix} - 9'd128);
        full_vec    = xv_q;
        full_vec[7] = px_s;
        seg_end     = (col_q[2:0] == 3'd7);
        line_end    = (col_q == CW'(IMG_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            line_q  <= '0;
            strip_q <= '0;
            bank_q  <= 1'b0;
            xv_q    <= '0;
            seg_q   <= '0;
            wact_q  <= 1'b0;
            wk_q    <= '0;
            done_q  <= 1'b0;
            dbank_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            // Drain of the current segment: one intermediate per cycle.
            if (wact_q) begin
                wk_q <= wk_q + 3'd1;
                if (wk_q == 3'd7) begin
                    wact_q <= 1'b0;
                    if (seg_q.last) begin
                        done_q  <= 1'b1;
                        dbank_q <= seg_q.bank;
                    end
                end
            end
            // Raster position tracking.
            if (vsync) begin
                col_q   <= '0;
                line_q  <= '0;
                strip_q <= '0;
                bank_q  <= 1'b0;
            end else if (hsync) begin
                col_q <= '0;
            end else if (pix_valid) begin
                xv_q[col_q[2:0]] <= px_s;
                if (seg_end) begin
                    seg_q.vec  <= full_vec;
                    seg_q.blk  <= BW'(col_q >> 3);
                    seg_q.line <= line_q;
                    seg_q.bank <= bank_q;
                    seg_q.last <= line_end && (line_q == 3'd7);
                    wact_q     <= 1'b1;
                    wk_q       <= '0;
                end
                if (line_end) begin
                    col_q <= '0;
                    if (line_q == 3'd7) begin
                        line_q <= '0;
                        if (strip_q == SW'(STRIPS - 1)) begin
                            strip_q <= '0;
                            bank_q  <= 1'b0;
                        end else begin
                            strip_q <= strip_q + SW'(1);
                            bank_q  <= ~bank_q;
                        end
                    end else begin
                        line_q <= line_q + 3'd1;
                    end
                end else begin
                    col_q <= col_q + CW'(1);
                end
            end
        end
    end

    // Transposed placement: frequency selects the group of 8, line the slot.
    always_comb begin
        wr_en      = wact_q;
        wr_data    = row_dot(seg_q.vec, wk_q);
        wr_addr    = AW'(int'(seg_q.bank) * HALF + int'(seg_q.blk) * 64
                         + int'(wk_q) * 8 + int'(seg_q.line));
        strip_done = done_q;
        strip_bank = dbank_q;
    end

endmodule

// File: rtl/dct_strip_mem.sv
module dct_strip_mem
    import dct_pkg::*;
#(
    parameter int DEPTH = 5632,
    parameter int AW    = 13
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  mid_t          wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output mid_t          rd_data
);

    mid_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
        if (rd_en)
            rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/dct_col_pass.sv
module dct_col_pass
    import dct_pkg::*;
#(
    parameter int IMG_W = 352,
    parameter int AW    = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_bank,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  mid_t          rd_data,
    output coef_t         coef,
    output logic          coef_valid,
    output logic          blk_start,
    output logic          busy
);

    localparam int HALF = 8 * IMG_W;
    localparam int HW   = $clog2(HALF);

    cp_state_t     st_q;
    logic [HW-1:0] cidx_q;
    logic          rbank_q;
    logic          dv_q;
    logic [5:0]    didx_q;
    midvec_t       ld_q;
    midvec_t       hv_q;
    logic [2:0]    grp_q;
    logic          oact_q;
    logic [2:0]    v_q;
    coef_t         coef_q;
    logic          cv_q;
    logic          bs_q;

    always_comb begin
        rd_en   = (st_q == CP_RUN);
        rd_addr = AW'(int'(rbank_q) * HALF + int'(cidx_q));
        busy    = (st_q == CP_RUN);
    end

    // Sequential read of the finished half.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CP_IDLE;
            cidx_q  <= '0;
            rbank_q <= 1'b0;
            dv_q    <= 1'b0;
            didx_q  <= '0;
        end else begin
            dv_q   <= rd_en;
            didx_q <= cidx_q[5:0];
            if (start) begin
                st_q    <= CP_RUN;
                cidx_q  <= '0;
                rbank_q <= start_bank;
            end else if (st_q == CP_RUN) begin
                cidx_q <= cidx_q + HW'(1);
                if (cidx_q == HW'(HALF - 1))
                    st_q <= CP_IDLE;
            end
        end
    end

    // Column gather, then eight outputs per gathered column.
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q   <= '0;
            hv_q   <= '0;
            grp_q  <= '0;
            oact_q <= 1'b0;
            v_q    <= '0;
            coef_q <= '0;
            cv_q   <= 1'b0;
            bs_q   <= 1'b0;
        end else begin
            coef_q <= col_dot(hv_q, v_q);
            cv_q   <= oact_q;
            bs_q   <= oact_q && (v_q == 3'd0) && (grp_q == 3'd0);
            if (oact_q) begin
                v_q <= v_q + 3'd1;
                if (v_q == 3'd7)
                    oact_q <= 1'b0;
            end
            if (dv_q) begin
                ld_q[didx_q[2:0]] <= rd_data;
                if (didx_q[2:0] == 3'd7) begin
                    hv_q       <= ld_q;
                    hv_q[7]    <= rd_data;
                    grp_q      <= didx_q[5:3];
                    oact_q     <= 1'b1;
                    v_q        <= '0;
                end
            end
        end
    end

    always_comb begin
        coef       = coef_q;
        coef_valid = cv_q;
        blk_start  = bs_q;
    end

endmodule

// File: rtl/strip_dct2d.sv
module strip_dct2d
    import dct_pkg::*;
#(
    parameter int IMG_W  = 352,
    parameter int STRIPS = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        pix,
    input  logic              pix_valid,
    input  logic              hsync,
    input  logic              vsync,
    output logic [11:0]       coef,
    output logic              coef_valid,
    output logic              blk_start
);

    localparam int DEPTH = 16 * IMG_W;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    mid_t          wr_data;
    logic          row_done;
    logic          row_bank;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    mid_t          rd_data;
    logic          col_busy;
    coef_t         coef_s;

    dct_row_pass #(.IMG_W(IMG_W), .STRIPS(STRIPS), .AW(AW)) u_row (
        .clk        (clk),
        .rst        (rst),
        .pix        (pix),
        .pix_valid  (pix_valid),
        .hsync      (hsync),
        .vsync      (vsync),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .strip_done (row_done),
        .strip_bank (row_bank)
    );

    dct_strip_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dct_col_pass #(.IMG_W(IMG_W), .AW(AW)) u_col (
        .clk        (clk),
        .rst        (rst),
        .start      (row_done),
        .start_bank (row_bank),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .coef       (coef_s),
        .coef_valid (coef_valid),
        .blk_start  (blk_start),
        .busy       (col_busy)
    );

    assign coef = coef_s;

endmodule

// File: rtl/strip_dct2d_chk.sv
module strip_dct2d_chk #(
    parameter int IMG_W = 352
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         coef_valid,
    input logic                         blk_start,
    input logic                         row_done,
    input logic                         col_busy,
    input logic                         wr_en,
    input logic [$clog2(16*IMG_W)-1:0]  wr_addr,
    input logic [$clog2(16*IMG_W)-1:0]  rd_addr
);

    localparam int AW   = $clog2(16 * IMG_W);
    localparam int HALF = 8 * IMG_W;

    logic [5:0] ocnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            ocnt_q <= '0;
        else if (coef_valid)
            ocnt_q <= ocnt_q + 6'd1;
    end

    // R3: the start flag only accompanies a valid coefficient
    p_start_valid_r3: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> coef_valid);

    // R3: start flag marks every 64th coefficient and no other
    p_block_len_r3: assert property (@(posedge clk) disable iff (rst)
        coef_valid |-> (blk_start == (ocnt_q == 6'd0)));

    // R3: a block is not interrupted
    p_contig_r3: assert property (@(posedge clk) disable iff (rst)
        (coef_valid && ocnt_q != 6'd63) |=> coef_valid);

    // R5: writes and reads stay in opposite halves
    p_half_apart_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && col_busy) |-> ((wr_addr >= AW'(HALF)) != (rd_addr >= AW'(HALF))));

    // R4: a strip never completes while the previous one is still being read
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        row_done |-> !col_busy);

endmodule

bind strip_dct2d strip_dct2d_chk #(.IMG_W(IMG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .coef_valid (coef_valid),
    .blk_start  (blk_start),
    .row_done   (row_done),
    .col_busy   (col_busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr)
);

// File: tb/sim_strip_dct2d.sv
module sim_strip_dct2d;

    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;
    localparam int  NS         = 2;
    localparam int  LINES      = 8 * NS;
    localparam int  SEGS       = W / 8;
    localparam int  NOUT       = NS * SEGS * 64;
    localparam int  WDOG       = 150000;
    localparam real PI         = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  pix;
    logic        pix_valid;
    logic        hsync;
    logic        vsync;
    logic [11:0] coef;
    logic        coef_valid;
    logic        blk_start;

    int checks = 0;
    int errors = 0;
    int nget   = 0;
    int fr    [LINES][W];
    int got_v [NOUT];
    bit got_s [NOUT];

    always #(CLK_PERIOD / 2) clk = ~clk;

    strip_dct2d #(.IMG_W(W), .STRIPS(NS)) u0 (
        .clk        (clk),
        .rst        (rst),
        .pix        (pix),
        .pix_valid  (pix_valid),
        .hsync      (hsync),
        .vsync      (vsync),
        .coef       (coef),
        .coef_valid (coef_valid),
        .blk_start  (blk_start)
    );

    always @(negedge clk) begin
        if (!rst && coef_valid) begin
            if (nget < NOUT) begin
                got_v[nget] = int'($signed(coef));
                got_s[nget] = blk_start;
            end
            nget++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real ref_coef(int s, int b, int u, int v);
        real acc = 0.0;
        real au  = (u == 0) ? $sqrt(0.125) : 0.5;
        real av  = (v == 0) ? $sqrt(0.125) : 0.5;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                acc += real'(fr[s*8 + r][b*8 + c] - 128)
                     * $cos(PI * real'((2*r + 1) * v) / 16.0)
                     * $cos(PI * real'((2*c + 1) * u) / 16.0);
        return au * av * acc;
    endfunction

    task automatic fill_frame(input int kind);
        for (int r = 0; r < LINES; r++)
            for (int c = 0; c < W; c++)
                case (kind)
                    0: fr[r][c] = 128;
                    1: fr[r][c] = (r < 8) ? ((c < 8) ? 0 : 255) : ((c < 8) ? 200 : 37);
                    4: fr[r][c] = (r * 13 + c * 7 + (((r ^ c) & 1) * 90)) % 256;
                    default: fr[r][c] = int'($urandom_range(0, 255));
                endcase
    endtask

    task automatic drive_line(input int r, input bit glitch, input bit junk);
        if (glitch) begin
            for (int g = 0; g < 3; g++) begin
                @(negedge clk);
                pix       = 8'($urandom_range(0, 255));
                pix_valid = 1'b1;
            end
            @(negedge clk);
            pix_valid = 1'b0;
        end
        @(negedge clk);
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        for (int c = 0; c < W; c++) begin
            while ($urandom_range(0, 3) == 0) begin
                pix_valid = 1'b0;
                @(negedge clk);
            end
            pix       = junk ? 8'($urandom_range(0, 255)) : 8'(fr[r][c]);
            pix_valid = 1'b1;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic run_frame(input int kind, input bit glitch, input bit exact, input string tag);
        fill_frame(kind);
        nget = 0;
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        for (int r = 0; r < LINES; r++)
            drive_line(r, glitch && (r % 3 == 1), 1'b0);
        repeat (400) @(negedge clk);
        // R4: every block of every strip, no more, no fewer
        check(nget == NOUT, {"R4 ", tag}, nget, NOUT);
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < SEGS; b++)
                for (int u = 0; u < 8; u++)
                    for (int v = 0; v < 8; v++) begin
                        int  idx = ((s * SEGS + b) * 64) + u * 8 + v;
                        real e   = ref_coef(s, b, u, v);
                        int  ei  = int'(e);
                        if (idx < nget) begin
                            if (exact) begin
                                // R10: flat blocks are exact
                                check(got_v[idx] == ei, {"R10 ", tag}, got_v[idx], ei);
                            end else begin
                                // R1 R2 R5 R8: value and position in the stream
                                real d = real'(got_v[idx]) - e;
                                check(d <= 1.0 && d >= -1.0, {"R1 R2 R5 R8 ", tag},
                                      got_v[idx], ei);
                            end
                            // R3: start flag on the first coefficient only
                            check(got_s[idx] == ((u == 0) && (v == 0)), {"R3 ", tag},
                                  int'(got_s[idx]), int'((u == 0) && (v == 0)));
                        end
                    end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", WDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst       = 1'b1;
        pix       = '0;
        pix_valid = 1'b0;
        hsync     = 1'b0;
        vsync     = 1'b0;
        repeat (4) @(negedge clk);
        // R9: quiet while in reset
        check(coef_valid == 1'b0, "R9 valid in reset", int'(coef_valid), 0);
        check(blk_start == 1'b0, "R9 start in reset", int'(blk_start), 0);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check(coef_valid == 1'b0, "R9 valid after reset", int'(coef_valid), 0);
        check(nget == 0, "R9 outputs after reset", nget, 0);

        run_frame(0, 1'b0, 1'b1, "flat mid");
        run_frame(1, 1'b0, 1'b1, "flat blocks");

        // R7: partial strip of junk lines, then a fresh frame after vsync
        nget = 0;
        for (int r = 0; r < 3; r++)
            drive_line(0, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        check(nget == 0, "R7 partial strip output", nget, 0);
        run_frame(2, 1'b0, 1'b0, "R7 after vsync");

        // R6: junk pixels then hsync ahead of several lines
        run_frame(3, 1'b1, 1'b0, "R6 hsync realign");
        run_frame(4, 1'b0, 1'b0, "ramp");
        run_frame(5, 1'b0, 1'b0, "random");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule